// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

A first-in first-out buffer for 9-bit words whose producer and consumer run on separate, unrelated clocks. Each side keeps its own pointer. The pointers cross between the clock domains as gray code through flop synchronisers. Full is computed on the write side and empty on the read side. Each flag can lag the true state, but only in the safe direction.

The block also has two programmable watermark outputs. An almost-empty flag and an almost-full flag compare the occupancy against two offsets. A load strobe writes the offsets from the data bus, the empty offset first and the full offset second. A read issued while the output enable is high still removes the word but does not present it, so the word is skipped. A retransmit input moves the read side back to address 0. This allows a stream written since reset to be read again, as long as that stream is no longer than the depth.

Top module: `rewind_fifo`

## Requirements
- R1: While reset is low and just after it, empty_n = 0, full_n = 1, pae_n = 0, paf_n = 1 and dout_vld = 0. Both offsets hold 7.
- R2: At a write-clock edge with wen_n = 0, ld_n = 1, not full and retransmit inactive, din is stored. Words leave in the order they were stored.
- R3: full_n is 0 when the write-side occupancy equals the depth. A write attempted while full is dropped and does not move the write pointer.
- R4: At a read-clock edge with ren_n = 0, rt_n = 1 and empty_n = 1, the oldest word is removed. With oe_n = 0 it appears on dout with dout_vld = 1 one read clock later. A read attempted while empty changes nothing.
- R5: A read taken with oe_n = 1 removes the word but leaves dout_vld = 0, so the word is skipped.
- R6: empty_n is 0 exactly when the read-side occupancy is zero. A write becomes visible to the read side within a few read clocks.
- R7: pae_n is 0 when the occupancy is at or below the empty offset.
- R8: paf_n is 0 when the free space (depth minus occupancy) is at or below the full offset.
- R9: A write-clock edge with ld_n = 0 copies din into an offset register and does not store a word. The first strobe after reset sets the empty offset, the second sets the full offset, and the third sets the empty offset again.
- R10: A read-clock edge with rt_n = 0 sets the read pointer to 0 and performs no read. The words written since reset can then be read again from the first one.
- R11: A write attempted while rt_n has been low long enough to be synchronised into the write domain is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset for both sides, active low |
| wen_n | input | 1 | Write request, active low |
| ld_n | input | 1 | Offset load strobe, active low, write clock |
| din | input | 9 | Write data, also the offset value during a load |
| ren_n | input | 1 | Read request, active low |
| oe_n | input | 1 | Present the read word, active low; high turns the read into a skip |
| rt_n | input | 1 | Retransmit: rewind the read pointer to 0, active low, read clock |
| dout | output | 9 | Read data |
| dout_vld | output | 1 | dout holds a freshly presented word |
| full_n | output | 1 | Full, active low |
| empty_n | output | 1 | Empty, active low |
| paf_n | output | 1 | Programmable almost-full, active low |
| pae_n | output | 1 | Programmable almost-empty, active low |

## Verification
The bench works on the watermark boundaries one word at a time: occupancy 3 against 4 for an empty offset of 3, and 507 against 506 for a full offset of 5. A comparator that is off by one flips the flag on the wrong side. The bench fills the buffer past its depth, so a missing full guard overwrites unread words and garbles the read stream. A third load strobe checks that the offset selector wraps back to the empty offset. Reads taken with the output enable high must consume their word silently. A retransmit must replay the stream from the first word, and writes attempted while the retransmit input is held low must be dropped. If the rewind goes to the wrong place, the rewind is ignored, or the writes are not blocked, the replayed data or the flag check after the rewind differs from the model.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
   localparam int DATA_W = 9;
   typedef enum logic {SEL_EMPTY_OFF = 1'b0, SEL_FULL_OFF = 1'b1} off_sel_e;
endpackage

// File: rtl/rwf_sync.sv
module rwf_sync #(
   parameter int W       = 1,
   parameter int STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rwf_g2b.sv
module rwf_g2b #(
   parameter int W = 10
) (
   input  logic [W-1:0] gray,
   output logic [W-1:0] bin
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bin[i] = ^gray[W-1:i];
   end
endmodule

// File: rtl/rwf_mem.sv
module rwf_mem #(
   parameter int DW    = 9,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rclk,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge wclk)
      if (we) store[waddr] <= wdata;

   always_ff @(posedge rclk)
      if (re) rdata <= store[raddr];
endmodule

// File: rtl/rwf_wr_ctrl.sv
module rwf_wr_ctrl import rwf_pkg::*; #(
   parameter int DW          = 9,
   parameter int DEPTH       = 512,
   parameter int SYNC_STAGES = 2,
   parameter int OFF_RST     = 7,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wen_n,
   input  logic          ld_n,
   input  logic [DW-1:0] din,
   input  logic          rt_n,
   input  logic [PW-1:0] rgray_s,
   output logic [PW-1:0] wbin,
   output logic [PW-1:0] wgray,
   output logic          we,
   output logic [AW-1:0] eoff,
   output logic [AW-1:0] foff,
   output logic          full_n,
   output logic          paf_n
);
   logic          rt_w;
   logic [PW-1:0] rbin_s, occ, space, wbin_nxt;
   logic          full;
   off_sel_e      sel;

   rwf_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rt_sync (
      .clk(wclk), .rst_n(rst_n), .d(~rt_n), .q(rt_w));

   rwf_g2b #(.W(PW)) u_rg2b (.gray(rgray_s), .bin(rbin_s));

   assign occ      = wbin - rbin_s;
   assign full     = (occ == PW'(DEPTH));
   assign space    = PW'(DEPTH) - occ;
   assign full_n   = ~full;
   assign paf_n    = ~(space <= {1'b0, foff});
   assign we       = ~wen_n & ld_n & ~full & ~rt_w;
   assign wbin_nxt = wbin + PW'(1);

   always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (we) begin
         wbin  <= wbin_nxt;
         wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end

   always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n) begin
         eoff <= AW'(OFF_RST);
         foff <= AW'(OFF_RST);
         sel  <= SEL_EMPTY_OFF;
      end else if (!ld_n) begin
         if (sel == SEL_EMPTY_OFF) begin
            eoff <= AW'(din);
            sel  <= SEL_FULL_OFF;
         end else begin
            foff <= AW'(din);
            sel  <= SEL_EMPTY_OFF;
         end
      end
endmodule

// File: rtl/rwf_rd_ctrl.sv
module rwf_rd_ctrl #(
   parameter int DEPTH = 512,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          ren_n,
   input  logic          oe_n,
   input  logic          rt_n,
   input  logic [PW-1:0] wgray_s,
   input  logic [AW-1:0] eoff_s,
   output logic [PW-1:0] rbin,
   output logic [PW-1:0] rgray,
   output logic          re,
   output logic          dout_vld,
   output logic          empty_n,
   output logic          pae_n
);
   logic [PW-1:0] wbin_s, occ, rbin_nxt;
   logic          empty;

   rwf_g2b #(.W(PW)) u_wg2b (.gray(wgray_s), .bin(wbin_s));

   assign occ      = wbin_s - rbin;
   assign empty    = (occ == '0);
   assign empty_n  = ~empty;
   assign pae_n    = ~(occ <= {1'b0, eoff_s});
   assign re       = ~ren_n & rt_n & ~empty;
   assign rbin_nxt = rbin + PW'(1);

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         dout_vld <= 1'b0;
      end else begin
         dout_vld <= re & ~oe_n;
         if (!rt_n) begin
            rbin  <= '0;
            rgray <= '0;
         end else if (re) begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
         end
      end
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo import rwf_pkg::*; #(
   parameter int DEPTH       = 512,
   parameter int SYNC_STAGES = 2,
   parameter int OFF_RST     = 7
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              wen_n,
   input  logic              ld_n,
   input  logic [DATA_W-1:0] din,
   input  logic              ren_n,
   input  logic              oe_n,
   input  logic              rt_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld,
   output logic              full_n,
   output logic              empty_n,
   output logic              paf_n,
   output logic              pae_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH != 512 && DEPTH != 1024 && DEPTH != 2048 &&
       DEPTH != 4096 && DEPTH != 8192) begin : g_bad_depth
      $error("rewind_fifo: DEPTH must be one of 512..8192, power of two");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rewind_fifo: SYNC_STAGES must be at least 2");
   end
   if (OFF_RST < 0 || OFF_RST >= DEPTH) begin : g_bad_off
      $error("rewind_fifo: OFF_RST out of range");
   end

   logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
   logic [AW-1:0] eoff, foff, eoff_s;
   logic          we, re;

   rwf_wr_ctrl #(.DW(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES),
                 .OFF_RST(OFF_RST)) u_wr (
      .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .ld_n(ld_n), .din(din),
      .rt_n(rt_n), .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray), .we(we),
      .eoff(eoff), .foff(foff), .full_n(full_n), .paf_n(paf_n));

   rwf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
      .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .oe_n(oe_n), .rt_n(rt_n),
      .wgray_s(wgray_s), .eoff_s(eoff_s), .rbin(rbin), .rgray(rgray),
      .re(re), .dout_vld(dout_vld), .empty_n(empty_n), .pae_n(pae_n));

   rwf_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

   rwf_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

   rwf_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL(AW'(OFF_RST))) u_eoff (
      .clk(rclk), .rst_n(rst_n), .d(eoff), .q(eoff_s));

   rwf_mem #(.DW(DATA_W), .DEPTH(DEPTH)) u_mem (
      .wclk(wclk), .we(we), .waddr(wbin[AW-1:0]), .wdata(din),
      .rclk(rclk), .re(re), .raddr(rbin[AW-1:0]), .rdata(dout));
endmodule

// File: rtl/rwf_chk.sv
module rwf_chk #(
   parameter int DEPTH = 512,
   localparam int PW = $clog2(DEPTH) + 1
) (
   input logic          wclk,
   input logic          rclk,
   input logic          rst_n,
   input logic          wen_n,
   input logic          ren_n,
   input logic          oe_n,
   input logic          rt_n,
   input logic          full_n,
   input logic          empty_n,
   input logic          paf_n,
   input logic          pae_n,
   input logic          dout_vld,
   input logic [PW-1:0] wbin,
   input logic [PW-1:0] rbin
);
   p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
      (!full_n && !wen_n) |=> $stable(wbin));

   p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rst_n)
      (!empty_n && !ren_n && rt_n) |=> $stable(rbin));

   p_skip_hides_word_r5: assert property (@(posedge rclk) disable iff (!rst_n)
      dout_vld |-> $past(!oe_n && !ren_n && rt_n));

   p_empty_in_low_mark_r7: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |-> !pae_n);

   p_full_in_high_mark_r8: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !paf_n);

   p_rewind_to_zero_r10: assert property (@(posedge rclk) disable iff (!rst_n)
      !rt_n |=> (rbin == '0));
endmodule

bind rewind_fifo rwf_chk #(.DEPTH(DEPTH)) u_chk (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .ren_n(ren_n),
   .oe_n(oe_n), .rt_n(rt_n), .full_n(full_n), .empty_n(empty_n),
   .paf_n(paf_n), .pae_n(pae_n), .dout_vld(dout_vld),
   .wbin(wbin), .rbin(rbin));

// File: tb/rewind_fifo_tb_top.sv
`timescale 1ns/1ps
module rewind_fifo_tb_top;
   localparam int DEPTH = 512;

   logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
   logic       wen_n = 1'b1, ld_n = 1'b1, ren_n = 1'b1, oe_n = 1'b0, rt_n = 1'b1;
   logic [8:0] din = '0;
   logic [8:0] dout;
   logic       dout_vld, full_n, empty_n, paf_n, pae_n;

   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   rewind_fifo #(.DEPTH(DEPTH)) dut_i (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .ld_n(ld_n),
      .din(din), .ren_n(ren_n), .oe_n(oe_n), .rt_n(rt_n), .dout(dout),
      .dout_vld(dout_vld), .full_n(full_n), .empty_n(empty_n),
      .paf_n(paf_n), .pae_n(pae_n));

   int         n_cmp = 0, n_err = 0;
   bit         done = 1'b0;
   logic [8:0] hist [$];
   int         ri = 0, eoff_m = 7, foff_m = 7, wcnt = 0;
   bit         sel_m = 1'b0;
   bit         exp_vld = 1'b0;
   logic [8:0] exp_d = '0;
   string      rd_tag = "R4";

   task automatic check(string req, int act, int exp, string what);
      n_cmp++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // write-side model, sampled mid-cycle
   always @(negedge wclk) if (rst_n) begin
      if (!ld_n) begin
         if (!sel_m) eoff_m = int'(din); else foff_m = int'(din);
         sel_m = ~sel_m;
      end else if (!wen_n && full_n && rt_n) begin
         hist.push_back(din);
      end
   end

   // read-side model, compared on every read clock
   always @(negedge rclk) begin
      if (!rst_n) begin
         exp_vld = 1'b0;
      end else begin
         check("R5", int'(dout_vld), int'(exp_vld), "dout_vld");
         if (exp_vld) check(rd_tag, int'(dout), int'(exp_d), "dout");
         if (!rt_n) begin
            ri = 0;
            exp_vld = 1'b0;
         end else if (!ren_n && empty_n) begin
            if (ri >= hist.size()) begin
               check("R6", int'(empty_n), 0, "empty_n with no stored word");
               exp_vld = 1'b0;
            end else begin
               exp_d   = hist[ri];
               exp_vld = !oe_n;
               ri++;
            end
         end else begin
            exp_vld = 1'b0;
         end
      end
   end

   task automatic settle();
      repeat (8) @(posedge rclk);
      repeat (8) @(posedge wclk);
      #2;
   endtask

   task automatic chk_flags(string tag);
      int cnt;
      cnt = hist.size() - ri;
      check({tag, " R6"}, int'(empty_n), int'(cnt != 0), "empty_n");
      check({tag, " R3"}, int'(full_n), int'(cnt != DEPTH), "full_n");
      check({tag, " R7"}, int'(pae_n), int'(!(cnt <= eoff_m)), "pae_n");
      check({tag, " R8"}, int'(paf_n), int'(!((DEPTH - cnt) <= foff_m)), "paf_n");
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      hist.delete();
      ri = 0; eoff_m = 7; foff_m = 7; sel_m = 1'b0;
      repeat (4) @(posedge wclk);
      #1 rst_n = 1'b1;
      settle();
   endtask

   task automatic wr(int n);
      @(posedge wclk); #1;
      wen_n = 1'b0;
      for (int k = 0; k < n; k++) begin
         din = 9'(wcnt * 29 + 3);
         wcnt++;
         @(posedge wclk); #1;
      end
      wen_n = 1'b1;
   endtask

   task automatic rd(int n, logic oe);
      @(posedge rclk); #1;
      ren_n = 1'b0; oe_n = oe;
      repeat (n) @(posedge rclk);
      #1 ren_n = 1'b1; oe_n = 1'b0;
   endtask

   task automatic load(int v);
      @(posedge wclk); #1;
      ld_n = 1'b0; din = 9'(v);
      @(posedge wclk); #1;
      ld_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_cmp++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      rst_n = 1'b0;
      repeat (3) @(posedge wclk);
      #1;
      check("R1", int'(empty_n), 0, "empty_n in reset");
      check("R1", int'(full_n), 1, "full_n in reset");
      check("R1", int'(pae_n), 0, "pae_n in reset");
      check("R1", int'(paf_n), 1, "paf_n in reset");
      check("R1", int'(dout_vld), 0, "dout_vld in reset");
      do_reset();
      chk_flags("R1");

      // R7 default boundary: 7 words low mark, 8 words above
      wr(7); settle(); chk_flags("R7 count7");
      wr(1); settle(); chk_flags("R7 count8");

      // R2 R4 R5: present 5, skip 3, then read on empty
      rd_tag = "R2";
      rd(5, 1'b0);
      rd(3, 1'b1);
      rd(3, 1'b0);
      settle(); chk_flags("R4 drained");

      // R10 R11: hold retransmit, attempt writes, release and replay
      @(posedge rclk); #1 rt_n = 1'b0;
      repeat (6) @(posedge wclk);
      wr(4);
      repeat (6) @(posedge wclk);
      @(posedge rclk); #1 rt_n = 1'b1;
      settle(); chk_flags("R11 after blocked writes");
      rd_tag = "R10";
      rd(8, 1'b0);
      settle(); chk_flags("R10 replayed");

      // R9 offset loading and wrap, R3 full, R8 high mark
      do_reset();
      rd_tag = "R2";
      load(3);
      load(5);
      wr(3); settle(); chk_flags("R9 eoff3 count3");
      wr(1); settle(); chk_flags("R9 eoff3 count4");
      wr(502); settle(); chk_flags("R8 free6");
      wr(1); settle(); chk_flags("R8 free5");
      wr(20); settle(); chk_flags("R3 full");
      load(100);
      settle(); chk_flags("R9 wrap full");
      rd(411, 1'b0); settle(); chk_flags("R9 wrap count101");
      rd(1, 1'b0); settle(); chk_flags("R9 wrap count100");
      rd(103, 1'b0); settle(); chk_flags("R3 drained");
      check("R3", hist.size(), DEPTH, "words accepted");

      finish_run();
   end
endmodule